// File: doc/BRIEF.md
# Addressable Nine-Bit Asynchronous Serial Port

This block is an asynchronous serial port for a bus of several nodes. It sends and receives frames with a start bit, eight data bits sent least significant bit first, an optional ninth bit and a stop bit. The receiver oversamples its line on an external oversampling tick. Each bit is decided by a two-of-three vote taken at the middle of the bit. A complete frame is offered to the host through a data buffer, a receive flag and a copy of the ninth bit.

In the nine-bit format the ninth bit marks a frame as an address. When address filtering is on, the port drops data frames. It keeps an address frame only if the frame matches one of two patterns. The first is the node's own address, in which any bit cleared in the mask register is a don't-care. The second is a group pattern formed from the address and the mask. Frames with a bad stop bit set a sticky error flag.

The host sees four write-selected registers: control, transmit data, own address and address mask. It reads the control/status byte and the receive buffer as plain outputs. The line rate is set entirely by the tick input, which runs at sixteen times the bit rate by default.

Top module: `uart9_port`

## Requirements
- R1: After reset the control/status byte reads 0x00, the receive buffer reads 0x00 and the transmit line is high.
- R2: A reception starts only on a high-to-low change of the receive line while the enable bit (control bit 0) is set. If the start bit votes high at its middle, the port drops the attempt, raises no flag and searches for an edge again.
- R3: Each bit value is the majority of three oversamples around the bit middle, so a disturbance lasting one oversample tick does not change a received bit.
- R4: With the nine-bit format (control bit 1) set, a frame is start, data bits 0 to 7, ninth bit, stop. A kept frame loads the buffer, copies the ninth bit to control bit 7 and sets the receive flag (control bit 4). The buffer and bit 7 change at no other time.
- R5: With control bit 1 clear, a frame has no ninth bit. Control bit 7 receives the sampled stop bit and the filter has no effect.
- R6: A frame that completes while the receive flag is set is discarded. The buffer, bit 7 and the flag keep their values.
- R7: With filtering on (control bit 2) in the nine-bit format, a frame whose ninth bit is 0 is discarded.
- R8: With filtering on, an address frame is kept when it equals the own-address register on every bit position where the mask register holds 1.
- R9: With filtering on, an address frame is kept when it has a 1 in every position where the address or the mask register holds 1. If that combined pattern is all zero, every address frame is kept.
- R10: With filtering on, an address frame that matches neither pattern is discarded and the receive flag stays clear.
- R11: A stop bit that votes low sets the framing-error flag (control bit 6). Later valid frames do not clear it. Only a control write with bit 6 at 0 clears it.
- R12: Writing the transmit-data register (select 1) while idle sends start 0, data bits 0 to 7, then the ninth bit taken from control bit 3 in the nine-bit format, then a high stop bit. The line idles high.
- R13: The transmit flag (control bit 5) is set when the stop bit begins and not before.
- R14: When the receiver or transmitter sets a flag in the same cycle as a host control write, the set wins over the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at the oversampling rate |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 transmit data, 2 own address, 3 mask |
| wr_data | input | W | Host write data |
| ctrl_q | output | 8 | Control/status: bit0 rx enable, bit1 nine-bit, bit2 filter, bit3 tx ninth bit, bit4 rx flag, bit5 tx flag, bit6 framing error, bit7 rx ninth bit |
| rx_buf | output | W | Last kept received byte |

## Verification
A host write to the control byte can land in the same cycle as the receiver finishing a frame and setting the receive flag. The bench provokes this by writing a cleared flag in every cycle while a frame arrives. It stops writing as soon as the flag reads high. Because the write was active on the edge that set the flag, a flag that comes up high shows that the hardware set won. A missing flag or a missing buffer load is reported as a failure. Loopback also runs the transmitter and receiver at the same time. This checks that the transmit flag and the reception result both arrive when the write ports are idle.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_e;

  localparam int unsigned CB_RXEN = 0;
  localparam int unsigned CB_NINE = 1;
  localparam int unsigned CB_FILT = 2;
  localparam int unsigned CB_TB8  = 3;
  localparam int unsigned CB_RXF  = 4;
  localparam int unsigned CB_TXF  = 5;
  localparam int unsigned CB_FERR = 6;
  localparam int unsigned CB_RB8  = 7;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart9_sync.sv
module uart9_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '1;
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/uart9_addr_match.sv
module uart9_addr_match #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] frame,
  input  logic [W-1:0] own,
  input  logic [W-1:0] mask,
  output logic         hit_given,
  output logic         hit_group
);
  logic [W-1:0] group;

  always_comb begin
    group     = own | mask;
    hit_given = (((frame ^ own) & mask) == '0);
    hit_group = ((frame & group) == group);
  end
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int unsigned OSR = 16,
  parameter int unsigned W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         rxd,
  input  logic         en,
  input  logic         nine,
  output logic         done,
  output logic [W-1:0] data,
  output logic         bit9,
  output logic         stop_ok
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned BW = $clog2(W + 1);
  localparam logic [CW-1:0] S_A   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] S_B   = CW'(OSR / 2);
  localparam logic [CW-1:0] S_C   = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] S_END = CW'(OSR - 1);

  rx_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] nbit_q, nbit_d;
  logic [W-1:0]  sh_q, sh_d;
  logic          b9_q, b9_d;
  logic          stop_q, stop_d;
  logic [1:0]    vs_q, vs_d;
  logic          last_q, last_d;
  logic          done_q, done_d;
  logic          vote;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    nbit_d = nbit_q;
    sh_d   = sh_q;
    b9_d   = b9_q;
    stop_d = stop_q;
    vs_d   = vs_q;
    last_d = last_q;
    done_d = 1'b0;
    vote   = maj3(vs_q[0], vs_q[1], rxd);

    if (tick) begin
      last_d = rxd;
      if (st_q == RX_IDLE) begin
        if (en && last_q && !rxd) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
      end else begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == S_A) vs_d[0] = rxd;
        if (cnt_q == S_B) vs_d[1] = rxd;
        if (cnt_q == S_C) begin
          unique case (st_q)
            RX_START: if (vote) st_d = RX_IDLE;
            RX_DATA:  sh_d = {vote, sh_q[W-1:1]};
            RX_NINTH: b9_d = vote;
            RX_STOP:  stop_d = vote;
            default:  ;
          endcase
        end
        if (cnt_q == S_END) begin
          cnt_d = '0;
          unique case (st_q)
            RX_START: begin
              st_d   = RX_DATA;
              nbit_d = '0;
            end
            RX_DATA: begin
              nbit_d = nbit_q + BW'(1);
              if (nbit_q == BW'(W - 1)) st_d = nine ? RX_NINTH : RX_STOP;
            end
            RX_NINTH: st_d = RX_STOP;
            RX_STOP: begin
              st_d   = RX_IDLE;
              done_d = 1'b1;
            end
            default: st_d = RX_IDLE;
          endcase
        end
      end
    end

    if (!en) begin
      st_d   = RX_IDLE;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      nbit_q <= '0;
      sh_q   <= '0;
      b9_q   <= 1'b0;
      stop_q <= 1'b1;
      vs_q   <= 2'b11;
      last_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      nbit_q <= nbit_d;
      sh_q   <= sh_d;
      b9_q   <= b9_d;
      stop_q <= stop_d;
      vs_q   <= vs_d;
      last_q <= last_d;
      done_q <= done_d;
    end
  end

  assign done    = done_q;
  assign data    = sh_q;
  assign bit9    = b9_q;
  assign stop_ok = stop_q;
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int unsigned OSR = 16,
  parameter int unsigned W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic         nine,
  input  logic         b9,
  input  logic [W-1:0] data,
  output logic         txd,
  output logic         busy,
  output logic         stop_begin
);
  localparam int unsigned FW = W + 3;
  localparam int unsigned LW = $clog2(FW + 1);
  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] S_END = CW'(OSR - 1);

  logic [FW-1:0] sh_q, sh_d;
  logic [LW-1:0] left_q, left_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stp_q, stp_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    cnt_d  = cnt_q;
    stp_d  = 1'b0;
    if (left_q == '0) begin
      if (start) begin
        sh_d   = {1'b1, (nine ? b9 : 1'b1), data, 1'b0};
        left_d = nine ? LW'(FW) : LW'(FW - 1);
        cnt_d  = '0;
      end
    end else if (tick) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == S_END) begin
        cnt_d  = '0;
        sh_d   = {1'b1, sh_q[FW-1:1]};
        left_d = left_q - LW'(1);
        if (left_q == LW'(2)) stp_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      stp_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      cnt_q  <= cnt_d;
      stp_q  <= stp_d;
    end
  end

  assign txd        = sh_q[0];
  assign busy       = (left_q != '0);
  assign stop_begin = stp_q;
endmodule

// File: rtl/uart9_port.sv
module uart9_port
  import uart9_pkg::*;
#(
  parameter int unsigned OSR  = 16,
  parameter int unsigned W    = 8,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         baud_tick,
  input  logic         rxd,
  output logic         txd,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [7:0]   ctrl_q,
  output logic [W-1:0] rx_buf
);
  logic rxd_s;
  logic rx_done, rx_b9, rx_stop;
  logic [W-1:0] rx_data;
  logic hit_given, hit_group;
  logic tx_busy, tx_stop;

  logic rxen_q, nine_q, filt_q, tb8_q, rxf_q, txf_q, ferr_q, rb8_q;
  logic rxen_d, nine_d, filt_d, tb8_d, rxf_d, txf_d, ferr_d, rb8_d;
  logic [W-1:0] own_q, own_d, mask_q, mask_d, buf_q, buf_d;
  logic wr_ctrl, wr_tx, keep;

  uart9_sync #(.STAGES(SYNC)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  uart9_rx #(.OSR(OSR), .W(W)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd_s),
    .en(rxen_q), .nine(nine_q), .done(rx_done), .data(rx_data),
    .bit9(rx_b9), .stop_ok(rx_stop)
  );

  uart9_addr_match #(.W(W)) match_i (
    .frame(rx_data), .own(own_q), .mask(mask_q),
    .hit_given(hit_given), .hit_group(hit_group)
  );

  uart9_tx #(.OSR(OSR), .W(W)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(wr_tx),
    .nine(nine_q), .b9(tb8_q), .data(wr_data), .txd(txd),
    .busy(tx_busy), .stop_begin(tx_stop)
  );

  always_comb begin
    wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    wr_tx   = wr_en && (wr_sel == SEL_DATA) && !tx_busy;
    keep    = rx_done && !rxf_q &&
              (!nine_q || !filt_q || (rx_b9 && (hit_given || hit_group)));

    rxen_d = wr_ctrl ? wr_data[CB_RXEN] : rxen_q;
    nine_d = wr_ctrl ? wr_data[CB_NINE] : nine_q;
    filt_d = wr_ctrl ? wr_data[CB_FILT] : filt_q;
    tb8_d  = wr_ctrl ? wr_data[CB_TB8]  : tb8_q;

    rxf_d  = keep ? 1'b1 : (wr_ctrl ? wr_data[CB_RXF] : rxf_q);
    txf_d  = tx_stop ? 1'b1 : (wr_ctrl ? wr_data[CB_TXF] : txf_q);
    ferr_d = (rx_done && !rx_stop) ? 1'b1 : (wr_ctrl ? wr_data[CB_FERR] : ferr_q);

    rb8_d  = keep ? (nine_q ? rx_b9 : rx_stop) : rb8_q;
    buf_d  = keep ? rx_data : buf_q;

    own_d  = (wr_en && (wr_sel == SEL_ADDR)) ? wr_data : own_q;
    mask_d = (wr_en && (wr_sel == SEL_MASK)) ? wr_data : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxen_q <= 1'b0;
      nine_q <= 1'b0;
      filt_q <= 1'b0;
      tb8_q  <= 1'b0;
      rxf_q  <= 1'b0;
      txf_q  <= 1'b0;
      ferr_q <= 1'b0;
      rb8_q  <= 1'b0;
      own_q  <= '0;
      mask_q <= '0;
      buf_q  <= '0;
    end else begin
      rxen_q <= rxen_d;
      nine_q <= nine_d;
      filt_q <= filt_d;
      tb8_q  <= tb8_d;
      rxf_q  <= rxf_d;
      txf_q  <= txf_d;
      ferr_q <= ferr_d;
      rb8_q  <= rb8_d;
      own_q  <= own_d;
      mask_q <= mask_d;
      buf_q  <= buf_d;
    end
  end

  assign ctrl_q = {rb8_q, ferr_q, txf_q, rxf_q, tb8_q, filt_q, nine_q, rxen_q};
  assign rx_buf = buf_q;
endmodule

// File: rtl/uart9_port_chk.sv
module uart9_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [7:0]   ctrl_q,
  input logic [W-1:0] rx_buf,
  input logic         txd
);
  logic wr_c;
  assign wr_c = wr_en && (wr_sel == 2'd0);

  AST_RX_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[4] && !wr_c) |=> ctrl_q[4]); // R6

  AST_BUF_FROZEN_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[4] && !wr_c) |=> $stable(rx_buf)); // R6

  AST_BUF_LOADS_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_buf) |-> $rose(ctrl_q[4])); // R4

  AST_NINTH_LOADS_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q[7]) |-> $rose(ctrl_q[4])); // R4

  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && !wr_c) |=> ctrl_q[6]); // R11

  AST_TX_FLAG_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_q[5]) && !$past(wr_c)) |-> txd); // R13
endmodule

bind uart9_port uart9_port_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .ctrl_q(ctrl_q), .rx_buf(rx_buf), .txd(txd)
);

// File: tb/uart9_port_tb_top.sv
module uart9_port_tb_top;
  localparam int BIT = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rxd_drv = 1'b1;
  logic       loop_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       rxd, txd;
  logic [7:0] ctrl_q, rx_buf;

  int n_vec = 0;
  int n_bad = 0;
  bit ended = 0;

  typedef struct {
    string      tag;
    logic [7:0] ctrl_e;
    logic [7:0] buf_e;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  assign rxd = loop_en ? txd : rxd_drv;

  uart9_port dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .txd(txd),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .rx_buf(rx_buf)
  );

  initial forever begin
    repeat (3) @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // monitor: compare rx status against the scoreboard
  initial forever begin
    @(negedge clk);
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " status"}, ctrl_q & 8'hD0, e.ctrl_e);
      check({e.tag, " buffer"}, rx_buf, e.buf_e);
    end
  end

  task automatic host_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic nine,
                            input logic stopv, input int glitch_bit);
    int total;
    total = nine ? 11 : 10;
    for (int k = 0; k < total; k++) begin
      logic v;
      if (k == 0)                 v = 1'b0;
      else if (k <= 8)            v = d[k-1];
      else if (nine && k == 9)    v = b9;
      else                        v = stopv;
      for (int c = 0; c < BIT; c++) begin
        @(negedge clk);
        rxd_drv = (k == glitch_bit && c >= 30 && c < 34) ? ~v : v;
      end
    end
    @(negedge clk);
    rxd_drv = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic expect_rx(input string tag, input logic rxf, input logic rb8,
                           input logic ferr, input logic [7:0] b);
    exp_t e;
    e.tag = tag;
    e.ctrl_e = {rb8, ferr, 1'b0, rxf, 4'b0000};
    e.buf_e = b;
    sb.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  task automatic decode_txd(input logic nine, output logic [7:0] d, output logic b9);
    int guard;
    guard = 0;
    while (txd === 1'b1 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (32) @(negedge clk);
    check("R12 start bit", txd, 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = txd;
    end
    b9 = 1'b1;
    if (nine) begin
      repeat (BIT) @(negedge clk);
      b9 = txd;
      check("R13 tx flag clear before stop", ctrl_q[5], 1'b0);
    end
    repeat (BIT) @(negedge clk);
    check("R12 stop bit", txd, 1'b1);
    check("R13 tx flag at stop", ctrl_q[5], 1'b1);
    repeat (BIT) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] td;
    logic       tb9;
    bit         seen;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctrl reset", ctrl_q, 8'h00);
    check("R1 buffer reset", rx_buf, 8'h00);
    check("R1 txd idle", txd, 1'b1);

    // nine-bit reception
    host_wr(2'd0, 8'h03);
    send_frame(8'hA5, 1'b1, 1'b1, 1'b1, -1);
    expect_rx("R4 frame A5/1", 1, 1, 0, 8'hA5);
    host_wr(2'd0, 8'h03);
    send_frame(8'h3C, 1'b0, 1'b1, 1'b1, -1);
    expect_rx("R4 frame 3C/0", 1, 0, 0, 8'h3C);

    // flag still set: frame dropped
    send_frame(8'h77, 1'b1, 1'b1, 1'b1, -1);
    expect_rx("R6 frame while full", 1, 0, 0, 8'h3C);
    host_wr(2'd0, 8'h03);

    // one-tick glitch at mid of data bit 2
    send_frame(8'h0F, 1'b1, 1'b1, 1'b1, 3);
    expect_rx("R3 glitch vote", 1, 1, 0, 8'h0F);
    host_wr(2'd0, 8'h03);

    // false start
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (16) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (11 * BIT) @(negedge clk);
    expect_rx("R2 false start", 0, 1, 0, 8'h0F);
    send_frame(8'h5A, 1'b0, 1'b1, 1'b1, -1);
    expect_rx("R2 frame after false start", 1, 0, 0, 8'h5A);

    // eight-bit format, stop into bit 7, filter ignored
    host_wr(2'd0, 8'h05);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1, -1);
    expect_rx("R5 eight-bit frame", 1, 1, 0, 8'hC3);

    // framing error
    host_wr(2'd0, 8'h03);
    send_frame(8'h11, 1'b0, 1'b1, 1'b0, -1);
    expect_rx("R11 bad stop", 1, 0, 1, 8'h11);
    host_wr(2'd0, 8'h43);
    send_frame(8'h22, 1'b1, 1'b1, 1'b1, -1);
    expect_rx("R11 error survives good frame", 1, 1, 1, 8'h22);
    host_wr(2'd0, 8'h03);
    @(negedge clk);
    check("R11 software clear", ctrl_q[6], 1'b0);

    // address filtering: own C0, mask FE
    host_wr(2'd2, 8'hC0);
    host_wr(2'd3, 8'hFE);
    host_wr(2'd0, 8'h07);
    send_frame(8'h55, 1'b0, 1'b1, 1'b1, -1);
    expect_rx("R7 data frame dropped", 0, 1, 0, 8'h22);
    send_frame(8'hC1, 1'b1, 1'b1, 1'b1, -1);
    expect_rx("R8 given address", 1, 1, 0, 8'hC1);
    host_wr(2'd0, 8'h07);
    send_frame(8'h80, 1'b1, 1'b1, 1'b1, -1);
    expect_rx("R10 no match", 0, 1, 0, 8'hC1);
    send_frame(8'hFF, 1'b1, 1'b1, 1'b1, -1);
    expect_rx("R9 group address", 1, 1, 0, 8'hFF);
    host_wr(2'd0, 8'h07);
    // group pattern all zero: any address kept
    host_wr(2'd2, 8'h00);
    host_wr(2'd3, 8'h00);
    send_frame(8'h13, 1'b1, 1'b1, 1'b1, -1);
    expect_rx("R9 all don't-care", 1, 1, 0, 8'h13);

    // R14: flag set collides with clearing writes
    host_wr(2'd0, 8'h03);
    seen = 0;
    fork
      send_frame(8'h6B, 1'b0, 1'b1, 1'b1, -1);
      begin
        for (int i = 0; i < 900; i++) begin
          @(negedge clk);
          if (ctrl_q[4] === 1'b1) begin
            seen = 1;
            wr_en = 1'b0;
            break;
          end
          wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h03;
        end
        wr_en = 1'b0;
      end
    join
    check("R14 set wins over write", seen, 1'b1);
    expect_rx("R14 buffer loaded", 1, 0, 0, 8'h6B);

    // transmitter with ninth bit 1
    host_wr(2'd0, 8'h0A);
    host_wr(2'd1, 8'h96);
    decode_txd(1'b1, td, tb9);
    check("R12 tx data", td, 8'h96);
    check("R12 tx ninth bit", tb9, 1'b1);

    // loopback: transmitter feeds receiver
    host_wr(2'd0, 8'h03);
    loop_en = 1'b1;
    host_wr(2'd1, 8'h3A);
    repeat (12 * BIT) @(negedge clk);
    expect_rx("R12 loopback frame", 1, 0, 0, 8'h3A);
    check("R13 loopback tx flag", ctrl_q[5], 1'b1);
    check("R12 line idle after frame", txd, 1'b1);

    finish_run();
  end
endmodule